// File: doc/BRIEF.md
# DRAM Controller Configuration Register Bank

This block holds the software-visible setup state of an SDRAM controller. Software reaches it over a simple valid/ready register bus that carries a window code, a word index (the byte offset divided by four, since every access is a full 32-bit word) and the write data. Three 4 KiB windows hold the registers: a common window with the memory-geometry control word, a controller window with the PHY start register and two status registers, and a PHY window of plain storage. A fourth window code reaches a sticky access-error flag.

A write of the geometry control word is decoded into row-address bits, bank-address bits and page size in bytes. These are held on registered outputs for an address-aliasing unit, and a one-cycle pulse tells that unit to re-evaluate. A write to the PHY start register marks the PHY as initialized and the controller as active by setting bit 0 of the two status registers. Out-of-range indices are handled safely: reads return zero, and writes are dropped and flagged as errors.

Top module: `dramcfg_regbank`

## Requirements
- R1: `req_ready` is always high. Every cycle with `req_valid` high gets exactly one response, with `rsp_valid` high in the following cycle, and no response appears otherwise.
- R2: Any in-range register that has no special behaviour keeps the 32-bit value last written to it and returns it on a read.
- R3: After reset, every register in all windows reads zero, the error flag is clear, and the geometry outputs show the decode of a zero control word (row bits 1, bank bits 2, page 8 bytes).
- R4: A write to controller-window index 0 (the PHY start register) stores its value there, and sets bit 0 of index 4 (PHY status) and of index 6 (controller status) while keeping their other bits. A direct write to index 4 or 6 replaces the whole register, bit 0 included.
- R5: One cycle after a write to common-window index 0, `geo_row_bits` = bits[7:4] + 1, `geo_bank_bits` = bit[2] + 2, and `geo_page_bytes` = 1 << (bits[11:8] + 3).
- R6: `cfg_update` is high for one cycle per accepted write to common-window index 0, in the same cycle as that write's response. Other writes never raise it.
- R7: A read at an index at or beyond a window's register count returns zero with `rsp_err` low.
- R8: A write at an out-of-range index changes no register, returns `rsp_err` high, and sets the sticky error flag.
- R9: Window code 3, index 0 reads the error flag in bit 0. Writing it with bit 0 set clears the flag, and writing it with bit 0 clear leaves the flag as it is. Other indices of that window are out of range.
- R10: Window codes are 0 for common, 1 for controller and 2 for PHY. The same index in different windows refers to separate storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 2 | Window code: 0 common, 1 controller, 2 PHY, 3 error flag |
| req_idx | input | IDX_W | Word index (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Write to an out-of-range index |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| geo_row_bits | output | 5 | Decoded row-address bits |
| geo_bank_bits | output | 2 | Decoded bank-address bits |
| geo_page_bytes | output | 19 | Decoded page size in bytes |
| cfg_update | output | 1 | One-cycle pulse after a control-word write |
| err_flag | output | 1 | Sticky access-error flag |

## Verification
Every response, the geometry outputs, the update pulse and the error flag all become valid one cycle after the clock edge that accepts the request. A status bit set by a start-register write is visible to a read issued in the very next cycle. The scoreboard stores, with each expected response, the cycle in which that response is due. The monitor compares at the falling edge and reports any response that comes early, late or not at all. Direct checks of the geometry, pulse and flag are taken at the falling edge right after the accepting edge, and the pulse is checked again one cycle later to confirm that it has dropped.

// File: rtl/dramcfg_pkg.sv
package dramcfg_pkg;

  typedef enum logic [1:0] {
    WIN_COM = 2'd0,
    WIN_CTL = 2'd1,
    WIN_PHY = 2'd2,
    WIN_ERR = 2'd3
  } win_e;

  localparam int COM_CTRL_IDX = 0;
  localparam int CTL_INIT_IDX = 0;
  localparam int CTL_GSR_IDX  = 4;
  localparam int CTL_STAT_IDX = 6;
  localparam int ERR_IDX      = 0;

  localparam int ROW_W  = 5;
  localparam int BANK_W = 2;
  localparam int PAGE_W = 19;

  typedef struct packed {
    logic [ROW_W-1:0]  row_bits;
    logic [BANK_W-1:0] bank_bits;
    logic [PAGE_W-1:0] page_bytes;
  } geom_t;

  function automatic geom_t decode_ctrl(input logic [3:0] row_f,
                                        input logic       bank_f,
                                        input logic [3:0] page_f);
    geom_t g;
    g.row_bits   = {1'b0, row_f} + 5'd1;
    g.bank_bits  = {1'b0, bank_f} + 2'd2;
    g.page_bytes = PAGE_W'(1) << ({1'b0, page_f} + 5'd3);
    return g;
  endfunction

endpackage

// File: rtl/dramcfg_window.sv
module dramcfg_window #(
  parameter int NREGS  = 64,
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit,
  output logic [DATA_W-1:0] rdata
);

  localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [DATA_W-1:0] mem [NREGS];
  logic [NREGS-1:0]  vld;
  logic [DATA_W-1:0] rd_q;
  logic              rd_vld_q;
  logic [AW-1:0]     addr;

  initial begin
    if (IDX_W < AW) $error("index too narrow for window depth");
  end

  assign addr = idx[AW-1:0];
  assign hit  = (int'(idx) < NREGS);

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we && hit) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re && hit) rd_q <= mem[addr];
  end

  // per-entry written flags give the zero-after-reset view
  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      if (we && hit) vld[addr] <= 1'b1;
      if (re) rd_vld_q <= hit && vld[addr];
    end
  end

  assign rdata = rd_vld_q ? rd_q : '0;

  // R8: an out-of-range write leaves the written flags untouched
  p_oob_write_blocked_r8: assert property (@(posedge clk) disable iff (rst)
    (we && !hit) |=> $stable(vld));

endmodule

// File: rtl/dramcfg_geom.sv
module dramcfg_geom
  import dramcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [3:0]        row_f,
  input  logic              bank_f,
  input  logic [3:0]        page_f,
  output logic [ROW_W-1:0]  row_bits,
  output logic [BANK_W-1:0] bank_bits,
  output logic [PAGE_W-1:0] page_bytes,
  output logic              update
);

  geom_t g_q;
  geom_t g_rst;

  assign g_rst = decode_ctrl(4'd0, 1'b0, 4'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      g_q    <= g_rst;
      update <= 1'b0;
    end else begin
      update <= ctrl_we;
      if (ctrl_we) g_q <= decode_ctrl(row_f, bank_f, page_f);
    end
  end

  assign row_bits   = g_q.row_bits;
  assign bank_bits  = g_q.bank_bits;
  assign page_bytes = g_q.page_bytes;

  // R5: decoded geometry always in the legal range
  p_bank_legal_r5: assert property (@(posedge clk) disable iff (rst)
    (bank_bits == 2'd2) || (bank_bits == 2'd3));
  p_row_legal_r5: assert property (@(posedge clk) disable iff (rst)
    (row_bits >= 5'd1) && (row_bits <= 5'd16));
  p_page_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(page_bytes) == 1);

endmodule

// File: rtl/dramcfg_status.sv
module dramcfg_status (
  input  logic clk,
  input  logic rst,
  input  logic init_we,
  input  logic gsr_we,
  input  logic gsr_bit,
  input  logic stat_we,
  input  logic stat_bit,
  input  logic bad_wr,
  input  logic err_clr,
  output logic init_done,
  output logic active,
  output logic err_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      init_done <= 1'b0;
      active    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (init_we)     init_done <= 1'b1;
      else if (gsr_we) init_done <= gsr_bit;
      if (init_we)      active <= 1'b1;
      else if (stat_we) active <= stat_bit;
      if (bad_wr)       err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  // R4: start-register write raises both status bits
  p_init_sets_flags_r4: assert property (@(posedge clk) disable iff (rst)
    init_we |=> (init_done && active));
  // R8: bad write raises the sticky error
  p_err_sets_r8: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> err_q);
  // R9: error flag holds unless set or cleared
  p_err_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (!bad_wr && !err_clr) |=> $stable(err_q));

endmodule

// File: rtl/dramcfg_regbank.sv
module dramcfg_regbank
  import dramcfg_pkg::*;
#(
  parameter int IDX_W    = 10,
  parameter int COM_REGS = 8,
  parameter int CTL_REGS = 64,
  parameter int PHY_REGS = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_win,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic [ROW_W-1:0]  geo_row_bits,
  output logic [BANK_W-1:0] geo_bank_bits,
  output logic [PAGE_W-1:0] geo_page_bytes,
  output logic              cfg_update,
  output logic              err_flag
);

  localparam int DATA_W = 32;

  initial begin
    if (CTL_REGS <= CTL_STAT_IDX) $error("controller window too small");
    if (COM_REGS <= COM_CTRL_IDX) $error("common window too small");
  end

  win_e win;
  logic acc, wr, rd;
  logic com_hit, ctl_hit, phy_hit, err_hit, sel_hit;
  logic [DATA_W-1:0] com_rd, ctl_rd, phy_rd;
  logic is_com, is_ctl, is_phy, is_err;
  logic ctrl_we, init_we, gsr_we, stat_we, bad_wr, err_clr;
  logic init_done, active;

  assign win       = win_e'(req_win);
  assign req_ready = 1'b1;
  assign acc       = req_valid;
  assign wr        = acc && req_write;
  assign rd        = acc && !req_write;
  assign is_com    = (win == WIN_COM);
  assign is_ctl    = (win == WIN_CTL);
  assign is_phy    = (win == WIN_PHY);
  assign is_err    = (win == WIN_ERR);
  assign err_hit   = (req_idx == IDX_W'(ERR_IDX));

  always_comb begin
    unique case (win)
      WIN_COM: sel_hit = com_hit;
      WIN_CTL: sel_hit = ctl_hit;
      WIN_PHY: sel_hit = phy_hit;
      default: sel_hit = err_hit;
    endcase
  end

  dramcfg_window #(.NREGS(COM_REGS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_com (
    .clk(clk), .rst(rst), .we(wr && is_com), .re(rd && is_com),
    .idx(req_idx), .wdata(req_wdata), .hit(com_hit), .rdata(com_rd)
  );

  dramcfg_window #(.NREGS(CTL_REGS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst(rst), .we(wr && is_ctl), .re(rd && is_ctl),
    .idx(req_idx), .wdata(req_wdata), .hit(ctl_hit), .rdata(ctl_rd)
  );

  dramcfg_window #(.NREGS(PHY_REGS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_phy (
    .clk(clk), .rst(rst), .we(wr && is_phy), .re(rd && is_phy),
    .idx(req_idx), .wdata(req_wdata), .hit(phy_hit), .rdata(phy_rd)
  );

  assign ctrl_we = wr && is_com && (req_idx == IDX_W'(COM_CTRL_IDX));
  assign init_we = wr && is_ctl && (req_idx == IDX_W'(CTL_INIT_IDX));
  assign gsr_we  = wr && is_ctl && (req_idx == IDX_W'(CTL_GSR_IDX));
  assign stat_we = wr && is_ctl && (req_idx == IDX_W'(CTL_STAT_IDX));
  assign bad_wr  = wr && !sel_hit;
  assign err_clr = wr && is_err && err_hit && req_wdata[0];

  dramcfg_status u_status (
    .clk(clk), .rst(rst),
    .init_we(init_we), .gsr_we(gsr_we), .gsr_bit(req_wdata[0]),
    .stat_we(stat_we), .stat_bit(req_wdata[0]),
    .bad_wr(bad_wr), .err_clr(err_clr),
    .init_done(init_done), .active(active), .err_q(err_flag)
  );

  dramcfg_geom u_geom (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we),
    .row_f(req_wdata[7:4]), .bank_f(req_wdata[2]), .page_f(req_wdata[11:8]),
    .row_bits(geo_row_bits), .bank_bits(geo_bank_bits),
    .page_bytes(geo_page_bytes), .update(cfg_update)
  );

  // response pipeline
  win_e rd_win_q;
  logic rd_ok_q, rd_oob_q, rd_gsr_q, rd_stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rd_ok_q   <= 1'b0;
      rd_oob_q  <= 1'b0;
      rd_gsr_q  <= 1'b0;
      rd_stat_q <= 1'b0;
      rd_win_q  <= WIN_COM;
    end else begin
      rsp_valid <= acc;
      rsp_err   <= bad_wr;
      rd_ok_q   <= rd && sel_hit;
      rd_oob_q  <= rd && !sel_hit;
      rd_win_q  <= win;
      rd_gsr_q  <= req_idx == IDX_W'(CTL_GSR_IDX);
      rd_stat_q <= req_idx == IDX_W'(CTL_STAT_IDX);
    end
  end

  logic [DATA_W-1:0] sel_rd;

  always_comb begin
    sel_rd = '0;
    unique case (rd_win_q)
      WIN_COM: sel_rd = com_rd;
      WIN_CTL: begin
        sel_rd = ctl_rd;
        if (rd_gsr_q)  sel_rd[0] = init_done;
        if (rd_stat_q) sel_rd[0] = active;
      end
      WIN_PHY: sel_rd = phy_rd;
      default: sel_rd = {{(DATA_W-1){1'b0}}, err_flag};
    endcase
  end

  assign rsp_rdata = rd_ok_q ? sel_rd : '0;

  // R1: one response per request, one cycle later
  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R7: out-of-range reads return zero
  p_oob_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rd_oob_q) |-> (rsp_rdata == '0 && !rsp_err));
  // R6: update pulse coincides with a good write response
  p_update_with_rsp_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_update |-> (rsp_valid && !rsp_err));
  // R8: error response raises the sticky flag
  p_err_rsp_flag_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> err_flag);

endmodule

// File: tb/dramcfg_regbank_tb.sv
`timescale 1ns/1ps
module dramcfg_regbank_tb;

  localparam int IDX_W = 10;
  localparam int NCOM = 8, NCTL = 64, NPHY = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic req_ready;
  logic [1:0] req_win = 2'd0;
  logic [IDX_W-1:0] req_idx = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err, cfg_update, err_flag;
  logic [31:0] rsp_rdata;
  logic [4:0] geo_row_bits;
  logic [1:0] geo_bank_bits;
  logic [18:0] geo_page_bytes;

  always #2.5 clk = ~clk;

  dramcfg_regbank #(.IDX_W(IDX_W), .COM_REGS(NCOM), .CTL_REGS(NCTL), .PHY_REGS(NPHY)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_win(req_win), .req_idx(req_idx), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .geo_row_bits(geo_row_bits), .geo_bank_bits(geo_bank_bits),
    .geo_page_bytes(geo_page_bytes), .cfg_update(cfg_update), .err_flag(err_flag)
  );

  typedef struct {
    logic [31:0] data;
    logic        err;
    int          due;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [31:0] m_com [NCOM];
  logic [31:0] m_ctl [NCTL];
  logic [31:0] m_phy [NPHY];
  bit m_err = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected responses in order
  always @(negedge clk) begin
    if (!rst) begin
      if (sbq.size() > 0 && sbq[0].due < cyc) begin
        n_cmp++; n_bad++;
        $display("FAIL R1 %s: no response, actual none expected cycle %0d", sbq[0].tag, sbq[0].due);
        void'(sbq.pop_front());
      end
      if (rsp_valid) begin
        n_cmp++;
        if (sbq.size() == 0) begin
          n_bad++;
          $display("FAIL R1 unexpected response: actual data %h, expected none", rsp_rdata);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          if (rsp_rdata !== e.data || rsp_err !== e.err || cyc != e.due) begin
            n_bad++;
            $display("FAIL %s: actual data %h err %b cycle %0d, expected data %h err %b cycle %0d",
                     e.tag, rsp_rdata, rsp_err, cyc, e.data, e.err, e.due);
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int wcount(input int w);
    case (w)
      0: return NCOM;
      1: return NCTL;
      2: return NPHY;
      default: return 1;
    endcase
  endfunction

  // driver: issues one request and records the expected response
  task automatic access(input bit wr, input int w, input int idx, input logic [31:0] d, input string tag);
    exp_t e;
    bit inr;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_win = 2'(w); req_idx = IDX_W'(idx); req_wdata = d;
    inr = idx < wcount(w);
    e.data = '0; e.err = 1'b0; e.due = cyc + 1; e.tag = tag;
    if (wr) begin
      if (!inr) begin e.err = 1'b1; m_err = 1'b1; end
      else case (w)
        0: m_com[idx] = d;
        1: begin
          m_ctl[idx] = d;
          if (idx == 0) begin m_ctl[4][0] = 1'b1; m_ctl[6][0] = 1'b1; end
        end
        2: m_phy[idx] = d;
        default: if (d[0]) m_err = 1'b0;
      endcase
    end else if (inr) begin
      case (w)
        0: e.data = m_com[idx];
        1: e.data = m_ctl[idx];
        2: e.data = m_phy[idx];
        default: e.data = {31'b0, m_err};
      endcase
    end
    sbq.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic ctrl_check(input logic [31:0] v);
    access(1, 0, 0, v, "R5 control write");
    idle();
    chk("R5 row bits",  32'(geo_row_bits),  32'(((v >> 4) & 15) + 1));
    chk("R5 bank bits", 32'(geo_bank_bits), 32'(((v >> 2) & 1) + 2));
    chk("R5 page bytes", 32'(geo_page_bytes), 32'(1) << (((v >> 8) & 15) + 3));
    chk("R6 update pulse high", 32'(cfg_update), 32'd1);
    @(negedge clk);
    chk("R6 update pulse one cycle", 32'(cfg_update), 32'd0);
  endtask

  initial begin
    foreach (m_com[i]) m_com[i] = '0;
    foreach (m_ctl[i]) m_ctl[i] = '0;
    foreach (m_phy[i]) m_phy[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R3 reset state
    chk("R3 geometry row", 32'(geo_row_bits), 32'd1);
    chk("R3 geometry bank", 32'(geo_bank_bits), 32'd2);
    chk("R3 geometry page", 32'(geo_page_bytes), 32'd8);
    chk("R3 error flag", 32'(err_flag), 32'd0);
    chk("R1 ready", 32'(req_ready), 32'd1);
    access(0, 0, 0, 0, "R3 common 0 after reset");
    access(0, 1, 4, 0, "R3 phy status after reset");
    access(0, 1, 6, 0, "R3 ctl status after reset");
    access(0, 2, 127, 0, "R3 phy last after reset");
    access(0, 3, 0, 0, "R3 error reg after reset");
    idle();

    // R2 / R10 storage, back-to-back and separated
    access(1, 0, 7, 32'hDEAD_BEEF, "R2 write common 7");
    access(1, 1, 63, 32'h1234_5678, "R2 write ctl 63");
    access(1, 2, 7, 32'hA5A5_5A5A, "R10 write phy 7");
    access(0, 0, 7, 0, "R10 read common 7");
    access(0, 1, 63, 0, "R2 read ctl 63");
    access(0, 2, 7, 0, "R10 read phy 7");
    access(0, 1, 7, 0, "R10 ctl 7 untouched");
    access(1, 2, 127, 32'hFFFF_FFFF, "R2 write phy last");
    idle();
    access(0, 2, 127, 0, "R2 read phy last");
    access(1, 1, 9, 32'h0000_0001, "R2 write ctl 9");
    access(0, 1, 9, 0, "R2 read ctl 9");
    idle();

    // R4 start register side effects
    access(1, 1, 4, 32'hABCD_0000, "R4 preset phy status");
    access(1, 1, 0, 32'h0000_01F2, "R4 start write");
    access(0, 1, 4, 0, "R4 phy status after start");
    access(0, 1, 6, 0, "R4 ctl status after start");
    access(0, 1, 0, 0, "R4 start value stored");
    access(1, 1, 4, 32'h0000_0000, "R4 direct write clears bit0");
    access(0, 1, 4, 0, "R4 phy status after direct write");
    idle();

    // R5 / R6 geometry decode
    ctrl_check(32'h0000_0000);
    ctrl_check(32'h0000_0AF4);
    ctrl_check(32'h0000_0F5B);
    ctrl_check(32'hFFFF_F0F0);
    access(0, 0, 0, 0, "R2 control readback");
    access(1, 2, 0, 32'h0000_0FF4, "R6 phy write");
    idle();
    chk("R6 no pulse for other window", 32'(cfg_update), 32'd0);
    chk("R5 geometry unchanged by phy write", 32'(geo_row_bits), 32'd16);

    // R7 out-of-range reads
    access(0, 0, 8, 0, "R7 common oob read");
    access(0, 1, 64, 0, "R7 ctl oob read");
    access(0, 2, 1023, 0, "R7 phy oob read");
    access(0, 3, 5, 0, "R7 error window oob read");
    idle();
    chk("R7 no error from reads", 32'(err_flag), 32'd0);

    // R8 out-of-range writes
    access(1, 0, 8, 32'h5555_5555, "R8 common oob write");
    idle();
    chk("R8 error flag set", 32'(err_flag), 32'd1);
    access(0, 0, 0, 0, "R8 alias common 0 unchanged");
    access(1, 2, 128, 32'h7777_7777, "R8 phy oob write");
    access(0, 2, 0, 0, "R8 alias phy 0 unchanged");
    idle();

    // R9 error register
    access(0, 3, 0, 0, "R9 read error set");
    access(1, 3, 0, 32'hFFFF_FFFE, "R9 write bit0 clear keeps flag");
    access(0, 3, 0, 0, "R9 flag still set");
    access(1, 3, 0, 32'h0000_0001, "R9 clear flag");
    access(0, 3, 0, 0, "R9 flag cleared");
    access(1, 3, 2, 32'h0000_0001, "R9 other index oob");
    access(0, 3, 0, 0, "R9 flag set again");
    idle();
    chk("R9 error port", 32'(err_flag), 32'd1);

    repeat (3) idle();
    chk("R1 all responses seen", 32'(sbq.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule